// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small field-programmable logic array. Four data inputs feed six AND gates, and each AND gate may take any input in true form, in inverted form, or both. Three OR gates each collect any subset of the six product terms and drive one output. Every connection is one bit of a configuration store, so both the AND plane and the OR plane can be rewritten at any time. The path from the data inputs to the outputs is purely combinational.

Configuration is loaded one product-term row at a time through a synchronous write port. A row carries eight literal-connection bits and three output-connection bits. A synchronous reset clears every connection, which leaves all product terms at 1 and all outputs at 0. Two rules follow directly from the connection model. A product term with no literals attached reads as constant 1. A term that receives both polarities of one input reads as constant 0. An output with no terms attached reads as constant 0.

Top module: `pla_array`

## Requirements
- R1: Reset (rst high at a rising clock edge) clears every connection bit. From that edge on, dout is 3'b000 for every din until a row is written.
- R2: Row bit 2*i connects din[i] to the product term, and row bit 2*i+1 connects ~din[i]. The product term is the AND of all connected literals.
- R3: A product term that has both bit 2*i and bit 2*i+1 set for some input i is 0 for every din. This includes the case with all eight literal bits set.
- R4: A product term with none of its eight literal bits set is constant 1.
- R5: Row bit 8+j connects that row's product term to dout[j], and dout[j] is the OR of the connected terms. An output with no connected term is 0.
- R6: When cfg_we is high at a rising edge, cfg_row is stored into row cfg_addr and takes effect from that edge. All other rows keep their contents, and nothing changes while cfg_we is low.
- R7: A write with cfg_addr of 6 or 7 (no such row) changes no row.
- R8: dout follows din with no clock edge in between.
- R9: Rows 0..5 can be loaded with the odd-value minterms 1, 3, 5, 7, 11 and 13. Output 0 takes all six, output 1 takes 1, 3 and 5, and output 2 takes 1, 3 and 13. With that load, dout matches those sets for all 16 din codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset; clears all connections |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 3 | Product-term row to write (0..5 valid) |
| cfg_row | input | 11 | Row contents: [7:0] literal bits, [10:8] output bits |
| din | input | 4 | Data inputs |
| dout | output | 3 | Combinational sum-of-products outputs |

## Verification
The odd-value load is swept over all 16 din codes. With overlapping output sets, a wrong OR column or a wrong literal polarity shows up as a mismatch on a particular code. Single-row patterns separate the three constant rules: an empty row, a row with a contradictory input pair, a fully connected row, and a row with no outputs attached. A row with mixed polarity, din[2] true and din[0] inverted, shows whether the true and inverted literal lines are swapped. Overwriting one row of the odd load and writing the two missing addresses shows whether writes leak into the other rows. Changing din between clock edges shows that the outputs follow din with no register in the path.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Literal line index for the true and inverted form of input i.
  function automatic int lit_true(input int i);
    return 2 * i;
  endfunction

  function automatic int lit_inv(input int i);
    return 2 * i + 1;
  endfunction

  // Width of one configuration row: literal bits followed by output bits.
  function automatic int row_width(input int n_in, input int n_out);
    return 2 * n_in + n_out;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_TERM = 6,
  parameter int ROW_W  = 11,
  parameter int ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [ROW_W-1:0]                wdata,
  output logic [N_TERM-1:0][ROW_W-1:0]    rows
);
  logic [N_TERM-1:0] row_sel;

  // One decoded enable per row, so an address with no row selects nothing.
  for (genvar k = 0; k < N_TERM; k++) begin : g_dec
    assign row_sel[k] = we && (addr == ADDR_W'(k));
  end

  for (genvar k = 0; k < N_TERM; k++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        rows[k] <= '0;
      end else if (row_sel[k]) begin
        rows[k] <= wdata;
      end
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]                din,
  input  logic [N_TERM-1:0][LIT_W-1:0]   conn,
  output logic [N_TERM-1:0]              term
);
  import pla_pkg::*;

  logic [LIT_W-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[lit_true(i)] = din[i];
    assign lits[lit_inv(i)]  = ~din[i];
  end

  // An unconnected literal is forced to 1, so it drops out of the AND.
  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    assign term[k] = &(lits | ~conn[k]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic [N_TERM-1:0]              term,
  input  logic [N_TERM-1:0][N_OUT-1:0]   conn,
  output logic [N_OUT-1:0]               sum
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar k = 0; k < N_TERM; k++) begin : g_col
      assign col[k] = conn[k][j];
    end
    assign sum[j] = |(term & col);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  localparam int LIT_W  = 2 * N_IN,
  localparam int ROW_W  = LIT_W + N_OUT,
  localparam int ADDR_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic [N_IN-1:0]   din,
  output logic [N_OUT-1:0]  dout
);
  logic [N_TERM-1:0][ROW_W-1:0] rows;
  logic [N_TERM-1:0][LIT_W-1:0] and_conn;
  logic [N_TERM-1:0][N_OUT-1:0] or_conn;
  logic [N_TERM-1:0]            term;

  pla_cfg_store #(.N_TERM(N_TERM), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_row),
    .rows  (rows)
  );

  for (genvar k = 0; k < N_TERM; k++) begin : g_split
    assign and_conn[k] = rows[k][LIT_W-1:0];
    assign or_conn[k]  = rows[k][ROW_W-1:LIT_W];
  end

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .din  (din),
    .conn (and_conn),
    .term (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term (term),
    .conn (or_conn),
    .sum  (dout)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  localparam int LIT_W  = 2 * N_IN,
  localparam int ROW_W  = LIT_W + N_OUT,
  localparam int ADDR_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         cfg_we,
  input logic [ADDR_W-1:0]            cfg_addr,
  input logic [ROW_W-1:0]             cfg_row,
  input logic [N_TERM-1:0][ROW_W-1:0] rows,
  input logic [N_TERM-1:0]            term,
  input logic [N_OUT-1:0]             dout
);
  function automatic logic [LIT_W-1:0] even_mask();
    logic [LIT_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_IN; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  localparam logic [LIT_W-1:0] EVEN = even_mask();

  // R1: the cycle after reset, all outputs are low
  a_r1_reset_outputs_low: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0));

  for (genvar k = 0; k < N_TERM; k++) begin : g_term_chk
    logic [LIT_W-1:0] lit;
    assign lit = rows[k][LIT_W-1:0];

    // R3: contradictory literal pair forces the term low
    a_r3_contradiction_zero: assert property (@(posedge clk) disable iff (rst)
      (|(lit & (lit >> 1) & EVEN)) |-> !term[k]);

    // R4: empty row gives a term of 1
    a_r4_empty_term_one: assert property (@(posedge clk) disable iff (rst)
      (lit == '0) |-> term[k]);

    // R6: a write lands in the addressed row
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == ADDR_W'(k)) |=> (rows[k] == $past(cfg_row)));

    // R6: rows not addressed hold their contents
    a_r6_row_kept: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && cfg_addr == ADDR_W'(k)) |=> $stable(rows[k]));
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
    logic [N_TERM-1:0] col;
    for (genvar k = 0; k < N_TERM; k++) begin : g_c
      assign col[k] = rows[k][LIT_W+j];
    end
    // R5: an output with no connected term is low
    a_r5_empty_output_zero: assert property (@(posedge clk) disable iff (rst)
      (col == '0) |-> !dout[j]);
  end

  // R7: a write to an address beyond the last row changes nothing
  a_r7_out_of_range_kept: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && {1'b0, cfg_addr} >= (ADDR_W+1)'(N_TERM)) |=> $stable(rows));
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_row  (cfg_row),
  .rows     (rows),
  .term     (term),
  .dout     (dout)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [10:0] cfg_row = '0;
  logic [3:0]  din = '0;
  logic [2:0]  dout;
  int n_chk = 0;
  int n_fail = 0;

  // Minterms for rows 0..5 and the output bits each feeds (dout[2:0]).
  localparam int         MINT [6] = '{1, 3, 5, 7, 11, 13};
  localparam logic [2:0] MOUT [6] = '{3'b111, 3'b111, 3'b011, 3'b001, 3'b001, 3'b101};
  // Expected dout for din codes 0..15 with the odd-value load.
  localparam logic [2:0] ODD_EXP [16] = '{
    3'b000, 3'b111, 3'b000, 3'b111, 3'b000, 3'b011, 3'b000, 3'b001,
    3'b000, 3'b000, 3'b000, 3'b001, 3'b000, 3'b101, 3'b000, 3'b000};

  always #2.5 clk = ~clk;

  pla_array dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_row(cfg_row), .din(din), .dout(dout)
  );

  function automatic logic [7:0] minterm_lits(input int m);
    logic [7:0] l;
    l = '0;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) l[2*i] = 1'b1;
      else      l[2*i+1] = 1'b1;
    end
    return l;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s: din=%0d dout=%b expected %b", req, din, dout, exp);
    end
  endtask

  task automatic write_row(input logic [2:0] a, input logic [10:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_row = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_odd();
    for (int k = 0; k < 6; k++) write_row(3'(k), {MOUT[k], minterm_lits(MINT[k])});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1: cleared array gives zero outputs for every input
    for (int c = 0; c < 16; c += 5) begin din = 4'(c); #0.5; check("R1", 3'b000); end

    // R9: odd-value load, walked over all codes
    load_odd();
    for (int c = 0; c < 16; c++) begin din = 4'(c); #0.5; check("R9", ODD_EXP[c]); end

    // R6: overwrite row 5 (minterm 13); other rows stay
    write_row(3'd5, 11'd0);
    din = 4'd13; #0.5; check("R6", 3'b000);
    din = 4'd1;  #0.5; check("R6", 3'b111);
    din = 4'd5;  #0.5; check("R6", 3'b011);

    // R7: addresses 6 and 7 hold no row
    do_reset();
    write_row(3'd6, {3'b111, 8'h00});
    write_row(3'd7, {3'b111, 8'h00});
    din = 4'd9; #0.5; check("R7", 3'b000);

    // R4: empty literal row is constant 1
    write_row(3'd0, {3'b001, 8'h00});
    din = 4'd0;  #0.5; check("R4", 3'b001);
    din = 4'd15; #0.5; check("R4", 3'b001);

    // R5: an active term with no output bits drives nothing; two outputs share a term
    write_row(3'd0, {3'b000, 8'h00});
    din = 4'd6; #0.5; check("R5", 3'b000);
    write_row(3'd0, {3'b101, 8'h00});
    #0.5; check("R5", 3'b101);

    // R3: both polarities of din[0] connected -> constant 0; likewise all eight
    write_row(3'd0, {3'b001, 8'b0000_0011});
    for (int c = 0; c < 16; c += 3) begin din = 4'(c); #0.5; check("R3", 3'b000); end
    write_row(3'd0, {3'b001, 8'hFF});
    din = 4'd15; #0.5; check("R3", 3'b000);

    // R2: term = din[2] & ~din[0]  (bit 4 and bit 1)
    write_row(3'd0, {3'b010, 8'b0001_0010});
    for (int c = 0; c < 16; c++) begin
      din = 4'(c); #0.5;
      check("R2", (c[2] && !c[0]) ? 3'b010 : 3'b000);
    end

    // R8: output follows din mid-cycle, without a clock edge
    @(posedge clk); #0.5;
    din = 4'd4; #0.2; check("R8", 3'b010);
    din = 4'd5; #0.2; check("R8", 3'b000);

    // R1: reset after a load clears it again
    load_odd();
    do_reset();
    din = 4'd1; #0.5; check("R1", 3'b000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule